// File: doc/BRIEF.md
# Bit-serial adder/subtractor

This unit adds or subtracts two WIDTH-bit operands with a single one-bit full adder and a carry flip-flop, handling one bit position per clock cycle, lowest position first. A start pulse captures both operands in parallel, together with the mode bit. The first operand goes into an accumulating shift register. Each sum bit is shifted back in at its top as the operand bits leave at its bottom. The second operand goes into its own shift register and leaves serially.

Subtraction uses the same datapath. Each bit of the second operand is inverted as it enters the full adder, and the carry flip-flop is preset to 1 instead of 0. The inverted bits plus that preset carry form the two's complement of the second operand. After WIDTH steps the result and the final carry are copied into output registers, and `done` pulses for one cycle. The result is correct for both unsigned and two's-complement operands. In subtract mode, a final carry of 1 means no borrow occurred.

Top module: `bitserial_addsub`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `done`, `result` and `carry_out` are all 0.
- R2: With `sub`=0 at acceptance, `result` equals (a + b) mod 2^WIDTH, and `carry_out` equals bit WIDTH of the full sum a + b.
- R3: With `sub`=1 at acceptance, `result` equals (a - b) mod 2^WIDTH, and `carry_out` is 1 exactly when a >= b as unsigned values (no borrow).
- R4: When `start` is sampled high at rising edge E while no operation is running, `done` is high for exactly one cycle, namely the cycle that follows edge E+WIDTH. It is low in every earlier cycle of that operation.
- R5: A `start` that is sampled high while an operation is running has no effect: no extra `done` pulse appears, and the running result is unchanged.
- R6: `result` and `carry_out` change only at the edge that raises `done`. At all other times they keep their values.
- R7: A `start` that is sampled high in the cycle in which `done` is high is accepted, so operations can follow each other with no idle cycle.
- R8: `a`, `b` and `sub` are read only at acceptance. Changing them while an operation is running does not alter its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins an operation when the unit is idle |
| sub | input | 1 | Mode: 0 add, 1 subtract |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand (subtrahend in subtract mode) |
| result | output | WIDTH | Registered sum or difference |
| carry_out | output | 1 | Final carry; in subtract mode 1 means no borrow |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The critical coincidence is a new `start` arriving right around the finish of the previous operation. A `start` held during the last bit step must be ignored. The same `start` in the cycle where `done` is high must be accepted. The bench chains operations back to back, so every new `start` lands in a `done` cycle. It also injects stray `start` pulses mid-run and in the final bit step. Each `done` is judged against a queued expectation, and `done` must stay silent in every other cycle. Operand and mode inputs are scrambled during every run to show that only the captured values count.

// File: rtl/serial_addsub_pkg.sv
package serial_addsub_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  // Carry preset: 0 for addition, 1 for subtraction (two's complement +1).
  function automatic logic carry_preset(op_e op);
    return (op == OP_SUB);
  endfunction

  // Bit of the second operand as seen by the adder.
  function automatic logic adder_y(op_e op, logic raw);
    return raw ^ (op == OP_SUB);
  endfunction

endpackage

// File: rtl/bs_full_adder.sv
module bs_full_adder (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);

  always_comb begin
    s  = x ^ y ^ ci;
    co = (x & y) | (x & ci) | (y & ci);
  end

endmodule

// File: rtl/bs_opnd_shreg.sv
// Operand register: parallel load, right shift, serial output at bit 0.
module bs_opnd_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic             ser_out
);

  logic [WIDTH-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (load)     q <= load_val;
    else if (shift_en) q <= {ser_in, q[WIDTH-1:1]};
  end

  assign ser_out = q[0];

endmodule

// File: rtl/bs_accum_shreg.sv
// Accumulating register: holds the first operand, shifts it out at bit 0
// while sum bits enter at the top; parallel view of every position.
module bs_accum_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic [WIDTH-1:0] par_out
);

  always_ff @(posedge clk) begin
    if (rst)           par_out <= '0;
    else if (load)     par_out <= load_val;
    else if (shift_en) par_out <= {ser_in, par_out[WIDTH-1:1]};
  end

endmodule

// File: rtl/bitserial_addsub.sv
module bitserial_addsub
  import serial_addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             sub,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             done
);

  localparam int            CNT_W    = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);

  logic             busy;
  logic [CNT_W-1:0] bit_cnt;
  op_e              op_q;
  logic             carry_q;
  logic             accept;
  logic [WIDTH-1:0] acc_q;
  logic             b_bit;
  logic             y_bit;
  logic             sum_bit;
  logic             cout;

  assign accept = start & ~busy;

  bs_accum_shreg #(.WIDTH(WIDTH)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (a),
    .shift_en (busy),
    .ser_in   (sum_bit),
    .par_out  (acc_q)
  );

  bs_opnd_shreg #(.WIDTH(WIDTH)) u_opb (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (b),
    .shift_en (busy),
    .ser_in   (1'b0),
    .ser_out  (b_bit)
  );

  assign y_bit = adder_y(op_q, b_bit);

  bs_full_adder u_fa (
    .x  (acc_q[0]),
    .y  (y_bit),
    .ci (carry_q),
    .s  (sum_bit),
    .co (cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      bit_cnt   <= '0;
      op_q      <= OP_ADD;
      carry_q   <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        bit_cnt <= '0;
        op_q    <= op_e'(sub);
        carry_q <= carry_preset(op_e'(sub));
      end else if (busy) begin
        carry_q <= cout;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          result    <= {sum_bit, acc_q[WIDTH-1:1]};
          carry_out <= cout;
        end
      end
    end
  end

endmodule

// File: rtl/bitserial_addsub_chk.sv
module bitserial_addsub_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             sub,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             done
);

  localparam int CNT_W = $clog2(WIDTH + 1);

  logic             armed;
  logic             m_busy;
  logic             m_fin;
  logic [CNT_W-1:0] m_cnt;
  logic [WIDTH-1:0] m_a;
  logic [WIDTH-1:0] m_b;
  logic             m_sub;
  logic [WIDTH:0]   m_exp;

  // Independent reference of timing and captured operands.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      m_busy <= 1'b0;
      m_fin  <= 1'b0;
      m_cnt  <= '0;
      m_a    <= '0;
      m_b    <= '0;
      m_sub  <= 1'b0;
    end else begin
      armed <= 1'b1;
      m_fin <= 1'b0;
      if (!m_busy && start) begin
        m_busy <= 1'b1;
        m_cnt  <= '0;
        m_a    <= a;
        m_b    <= b;
        m_sub  <= sub;
      end else if (m_busy) begin
        m_cnt <= m_cnt + 1'b1;
        if (m_cnt == CNT_W'(WIDTH - 1)) begin
          m_busy <= 1'b0;
          m_fin  <= 1'b1;
        end
      end
    end
  end

  assign m_exp = m_sub ? ({1'b0, m_a} + {1'b0, ~m_b} + (WIDTH+1)'(1))
                       : ({1'b0, m_a} + {1'b0, m_b});

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!done && result == '0 && !carry_out));

  p_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (done && !m_sub) |-> (result == m_exp[WIDTH-1:0] && carry_out == m_exp[WIDTH]));

  p_diff_r3: assert property (@(posedge clk) disable iff (rst)
    (done && m_sub) |-> (result == m_exp[WIDTH-1:0] && carry_out == (m_a >= m_b)));

  p_done_time_r4: assert property (@(posedge clk) disable iff (rst)
    armed |-> (done == m_fin));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && !done) |-> ($stable(result) && $stable(carry_out)));

endmodule

bind bitserial_addsub bitserial_addsub_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .sub       (sub),
  .a         (a),
  .b         (b),
  .result    (result),
  .carry_out (carry_out),
  .done      (done)
);

// File: tb/tb_bitserial_addsub.sv
`timescale 1ns/1ps
module tb_bitserial_addsub;

  localparam int W = 8;
  localparam time TCK = 4ns;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         sub;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         op_sub = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [W-1:0] result;
  logic         carry_out;
  logic         done;

  item_t        sb_q[$];
  int           checks = 0;
  int           fails = 0;
  bit           finished = 1'b0;
  bit           mon_en = 1'b0;
  logic [W-1:0] last_res = '0;
  logic         last_c = 1'b0;

  always #(TCK/2) clk = ~clk;

  bitserial_addsub #(.WIDTH(W)) dut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .sub       (op_sub),
    .a         (op_a),
    .b         (op_b),
    .result    (result),
    .carry_out (carry_out),
    .done      (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every done, otherwise checks hold (R6).
  always @(negedge clk) begin
    if (mon_en && !finished) begin
      if (done) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected done", {1'b0, result}, '0);
        end else begin
          item_t it;
          logic [W:0] full;
          it = sb_q.pop_front();
          if (it.sub) begin
            full = {1'b0, it.a} - {1'b0, it.b};
            chk(result == full[W-1:0], "R3", "difference", {1'b0, result}, {1'b0, full[W-1:0]});
            chk(carry_out == (it.a >= it.b), "R3", "no-borrow flag",
                {{W{1'b0}}, carry_out}, {{W{1'b0}}, (it.a >= it.b)});
          end else begin
            full = {1'b0, it.a} + {1'b0, it.b};
            chk(result == full[W-1:0], "R2", "sum", {1'b0, result}, {1'b0, full[W-1:0]});
            chk(carry_out == full[W], "R2", "carry",
                {{W{1'b0}}, carry_out}, {{W{1'b0}}, full[W]});
          end
        end
        last_res = result;
        last_c   = carry_out;
      end else begin
        chk(result == last_res && carry_out == last_c, "R6", "hold",
            {carry_out, result}, {last_c, last_res});
      end
    end
  end

  // Driver: called at a negedge; returns at the negedge where done is high.
  // poke injects start in mid-run and in the final bit step (R5); operands
  // are scrambled while running (R8). A following call starts in the done
  // cycle (R7).
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic s, input bit poke);
    item_t it;
    it.a = a; it.b = b; it.sub = s;
    sb_q.push_back(it);
    start = 1'b1; op_a = a; op_b = b; op_sub = s;
    for (int j = 1; j <= W + 1; j++) begin
      @(negedge clk);
      start  = poke && (j == W || j == W/2);
      op_a   = W'($urandom);
      op_b   = W'($urandom);
      op_sub = 1'($urandom);
      if (j <= W) chk(done == 1'b0, "R4", "early done", {{W{1'b0}}, done}, '0);
      else        chk(done == 1'b1, "R4", "done timing", {{W{1'b0}}, done}, 1);
    end
  endtask

  task automatic idle(input int n);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(done == 1'b0, "R5", "stray done", {{W{1'b0}}, done}, '0);
    end
  endtask

  initial begin
    #(TCK * 200000);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0,      "R1", "done in reset",   {{W{1'b0}}, done}, '0);
    chk(result == '0,      "R1", "result in reset", {1'b0, result}, '0);
    chk(carry_out == 1'b0, "R1", "carry in reset",  {{W{1'b0}}, carry_out}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && result == '0 && carry_out == 1'b0, "R1", "after reset",
        {done, result}, '0);
    mon_en = 1'b1;

    // Directed corners, back to back (R7).
    run_op(8'd5,   8'd9,   1'b0, 1'b0);
    run_op(8'd255, 8'd1,   1'b0, 1'b0);
    run_op(8'd255, 8'd255, 1'b0, 1'b1);
    idle(4);
    run_op(8'd0,   8'd0,   1'b1, 1'b0);
    run_op(8'd0,   8'd1,   1'b1, 1'b1);
    idle(3);
    run_op(8'd9,   8'd5,   1'b1, 1'b0);
    run_op(8'd128, 8'd128, 1'b1, 1'b0);
    run_op(8'd127, 8'd128, 1'b1, 1'b0);

    // Random operations with occasional stray starts and gaps.
    for (int k = 0; k < 600; k++) begin
      run_op(W'($urandom), W'($urandom), 1'($urandom), (k % 7) == 3);
      if ((k % 11) == 5) idle(2);
    end
    idle(5);
    chk(sb_q.size() == 0, "R4", "pending results", (W+1)'(sb_q.size()), '0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule